// File: doc/BRIEF.md
# Rational Tuning Word Calculator

This block converts an exact frequency ratio M/N, already reduced to lowest terms, into the three-part tuning word that drives a phase accumulator with a programmable modulus. The word has three fields: an integer step X and a fractional correction A/B. Together they make the accumulator advance by exactly M/N of a full turn per sample, so the output frequency carries no rounding error.

After one `start` strobe the unit divides M·2^32 by N with exact wide-integer long division, one quotient bit per clock. It then reduces the remainder fraction Y/N with a binary GCD and divides both terms by that GCD.

It also checks the input pair. N must fall in a range that a 32-bit word can represent, and M must lie below N/2 so that the output is usable. A pair that fails either check completes at once with the valid flag low. A `done` pulse marks every completion. The results then stay unchanged until the next accepted start.

Top module: `rational_tuning_calc`

## Requirements
- R1: After reset, `done`, `resultValid` and `modNeeded` are 0, and `wordX`, `fracA` and `fracB` are 0.
- R2: For a valid input, `wordX` equals floor(M·2^32 / N), computed exactly for operands up to 64 bits.
- R3: For a valid input with nonzero remainder Y = M·2^32 − X·N, `fracA`/`fracB` equals Y/N reduced to lowest terms. For example, M=1 and N=10 give X=429496729, A=3, B=5.
- R4: N is accepted in two cases: 3 ≤ N ≤ 2^32, or bits [31:0] of N are zero and bits [63:32] hold a value K with 2 ≤ K ≤ 2^32−1. Any other N completes with `resultValid`=0, `modNeeded`=0 and X=A=B=0.
- R5: An input with 2·M ≥ N completes with `resultValid`=0, `modNeeded`=0 and X=A=B=0.
- R6: When a valid input gives Y = 0, the block reports `modNeeded`=0, A=0 and B=1.
- R7: When a valid input gives Y ≠ 0, the block reports `modNeeded`=1 and 0 < A < B.
- R8: `done` is high for exactly one cycle per accepted start. All result outputs hold their values until the next accepted start.
- R9: A `start` that arrives while a calculation is running is ignored. Its operands do not change the result, and it produces no extra `done`.
- R10: `done` rises no more than 512 cycles after the cycle in which `start` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| ratioM | input | 64 | Numerator M of the frequency ratio |
| ratioN | input | 64 | Denominator N of the frequency ratio |
| wordX | output | 32 | Integer part X of the tuning word |
| fracA | output | 32 | Reduced numerator A of the fractional part |
| fracB | output | 32 | Reduced denominator B of the fractional part |
| resultValid | output | 1 | The input pair was accepted and the results are meaningful |
| modNeeded | output | 1 | The fractional part is nonzero, so modulus correction is required |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions check several properties on every cycle. The divider's partial remainder always stays below its divisor. The GCD loop never steps with a zero operand. Every valid completion reports either a proper fraction 0 < A < B or the pair 0/1, and a rejected pair leaves all three words at zero. Outputs stay unchanged while the unit is idle and no start arrives.

Only the bench's scenarios can show that the values themselves are correct. These scenarios cover exact quotients for operands near the 64-bit limit, reduction to lowest terms, the boundaries of the accepted N ranges, the M/N ≥ 1/2 rejection, and a start that arrives while a calculation is running.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [1:0] {
    SEL_X = 2'd0,
    SEL_A = 2'd1,
    SEL_B = 2'd2
  } divSel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHK, ST_DIVX, ST_GRABX, ST_GCD,
    ST_DIVA, ST_GRABA, ST_DIVB, ST_GRABB, ST_FIN
  } twState_e;

  typedef struct packed {
    logic    cap;
    logic    divLoad;
    divSel_e divSel;
    logic    divStep;
    logic    grabX;
    logic    gcdStep;
    logic    grabA;
    logic    grabB;
    logic    finish;
  } twStrobe_t;

endpackage

// File: rtl/tw_divider.sv
module tw_divider #(
  parameter int WORD_W = 32,
  parameter int DIVS_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              step,
  input  logic [DIVS_W-1:0] hiIn,
  input  logic [WORD_W-1:0] loIn,
  input  logic [DIVS_W-1:0] dIn,
  output logic [WORD_W-1:0] quot,
  output logic [DIVS_W-1:0] rem
);
  logic [DIVS_W-1:0] remReg, dReg;
  logic [WORD_W-1:0] loReg, quotReg;
  logic              loaded;
  logic [DIVS_W:0]   trial, diff;
  logic              fits;

  always_comb begin
    trial = {remReg, loReg[WORD_W-1]};
    diff  = trial - {1'b0, dReg};
    fits  = trial >= {1'b0, dReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg  <= '0;
      dReg    <= '0;
      loReg   <= '0;
      quotReg <= '0;
      loaded  <= 1'b0;
    end else if (load) begin
      remReg  <= hiIn;
      dReg    <= dIn;
      loReg   <= loIn;
      quotReg <= '0;
      loaded  <= 1'b1;
    end else if (step) begin
      remReg  <= fits ? diff[DIVS_W-1:0] : trial[DIVS_W-1:0];
      loReg   <= {loReg[WORD_W-2:0], 1'b0};
      quotReg <= {quotReg[WORD_W-2:0], fits};
    end
  end

  assign quot = quotReg;
  assign rem  = remReg;

  // R2: a restoring step is only correct while the partial remainder is below the divisor
  p_rem_below_r2: assert property (@(posedge clk) disable iff (!rstN)
    loaded |-> (remReg < dReg));

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      inputOk,
  input  logic      remZero,
  input  logic      gcdDone,
  output twStrobe_t st,
  output logic      busy
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WORD_W - 1);

  twState_e state, nextState;
  logic [CNT_W-1:0] cnt;
  logic inDiv;

  always_comb begin
    st        = '0;
    st.divSel = SEL_X;
    nextState = state;
    inDiv     = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        st.cap    = 1'b1;
        nextState = ST_CHK;
      end
      ST_CHK: begin
        if (inputOk) begin
          st.divLoad = 1'b1;
          st.divSel  = SEL_X;
          nextState  = ST_DIVX;
        end else begin
          nextState = ST_FIN;
        end
      end
      ST_DIVX: begin
        inDiv      = 1'b1;
        st.divStep = 1'b1;
        if (cnt == LAST_STEP) nextState = ST_GRABX;
      end
      ST_GRABX: begin
        st.grabX  = 1'b1;
        nextState = remZero ? ST_FIN : ST_GCD;
      end
      ST_GCD: begin
        if (gcdDone) begin
          st.divLoad = 1'b1;
          st.divSel  = SEL_A;
          nextState  = ST_DIVA;
        end else begin
          st.gcdStep = 1'b1;
        end
      end
      ST_DIVA: begin
        inDiv      = 1'b1;
        st.divStep = 1'b1;
        st.divSel  = SEL_A;
        if (cnt == LAST_STEP) nextState = ST_GRABA;
      end
      ST_GRABA: begin
        st.grabA   = 1'b1;
        st.divLoad = 1'b1;
        st.divSel  = SEL_B;
        nextState  = ST_DIVB;
      end
      ST_DIVB: begin
        inDiv      = 1'b1;
        st.divStep = 1'b1;
        st.divSel  = SEL_B;
        if (cnt == LAST_STEP) nextState = ST_GRABB;
      end
      ST_GRABB: begin
        st.grabB  = 1'b1;
        nextState = ST_FIN;
      end
      ST_FIN: begin
        st.finish = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= inDiv ? cnt + 1'b1 : '0;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/tw_datapath.sv
module tw_datapath
  import tw_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  twStrobe_t           st,
  input  logic [2*WORD_W-1:0] mIn,
  input  logic [2*WORD_W-1:0] nIn,
  output logic                inputOk,
  output logic                remZero,
  output logic                gcdDone,
  output logic [WORD_W-1:0]   xOut,
  output logic [WORD_W-1:0]   aOut,
  output logic [WORD_W-1:0]   bOut,
  output logic                validOut,
  output logic                modOut,
  output logic                doneOut
);
  localparam int RATIO_W = 2 * WORD_W;
  localparam int K_W     = $clog2(RATIO_W);

  logic [RATIO_W-1:0] mReg, nReg, yReg, gu, gv, gcdVal;
  logic [K_W-1:0]     gk;
  logic [WORD_W-1:0]  xReg, aReg, bReg;
  logic               validReg, modReg, doneReg;
  logic [RATIO_W-1:0] divHi, divD, divRem;
  logic [WORD_W-1:0]  divLo, divQuot;
  logic [WORD_W-1:0]  nHi, nLo;
  logic               smallOk, bigOk, ratioOk;

  always_comb begin
    nHi     = nReg[RATIO_W-1:WORD_W];
    nLo     = nReg[WORD_W-1:0];
    smallOk = ((nHi == '0) && (nLo >= WORD_W'(3))) || ((nHi == WORD_W'(1)) && (nLo == '0));
    bigOk   = (nLo == '0) && (nHi >= WORD_W'(2));
    ratioOk = {mReg, 1'b0} < {1'b0, nReg};
    inputOk = (smallOk || bigOk) && ratioOk;
    gcdVal  = (gu | gv) << gk;
    gcdDone = (gu == '0) || (gv == '0);
    remZero = (divRem == '0);
  end

  always_comb begin
    unique case (st.divSel)
      SEL_X: begin
        divHi = mReg;
        divLo = '0;
        divD  = nReg;
      end
      SEL_A: begin
        divHi = {{WORD_W{1'b0}}, yReg[RATIO_W-1:WORD_W]};
        divLo = yReg[WORD_W-1:0];
        divD  = gcdVal;
      end
      default: begin
        divHi = {{WORD_W{1'b0}}, nHi};
        divLo = nLo;
        divD  = gcdVal;
      end
    endcase
  end

  tw_divider #(.WORD_W(WORD_W), .DIVS_W(RATIO_W)) u_div (
    .clk  (clk),
    .rstN (rstN),
    .load (st.divLoad),
    .step (st.divStep),
    .hiIn (divHi),
    .loIn (divLo),
    .dIn  (divD),
    .quot (divQuot),
    .rem  (divRem)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mReg <= '0; nReg <= '0; yReg <= '0;
      gu <= '0; gv <= '0; gk <= '0;
      xReg <= '0; aReg <= '0; bReg <= '0;
      validReg <= 1'b0; modReg <= 1'b0; doneReg <= 1'b0;
    end else begin
      doneReg <= st.finish;
      if (st.cap) begin
        mReg <= mIn; nReg <= nIn; yReg <= '0;
        xReg <= '0; aReg <= '0; bReg <= '0;
        validReg <= 1'b0; modReg <= 1'b0;
      end
      if (st.grabX) begin
        xReg <= divQuot;
        yReg <= divRem;
        gu   <= divRem;
        gv   <= nReg;
        gk   <= '0;
        if (divRem == '0) bReg <= WORD_W'(1);
      end
      if (st.gcdStep) begin
        if (!gu[0] && !gv[0]) begin
          gu <= gu >> 1;
          gv <= gv >> 1;
          gk <= gk + 1'b1;
        end else if (!gu[0]) begin
          gu <= gu >> 1;
        end else if (!gv[0]) begin
          gv <= gv >> 1;
        end else if (gu >= gv) begin
          gu <= gu - gv;
        end else begin
          gv <= gv - gu;
        end
      end
      if (st.grabA) aReg <= divQuot;
      if (st.grabB) bReg <= divQuot;
      if (st.finish) begin
        validReg <= inputOk;
        modReg   <= inputOk && (yReg != '0);
      end
    end
  end

  assign xOut     = xReg;
  assign aOut     = aReg;
  assign bOut     = bReg;
  assign validOut = validReg;
  assign modOut   = modReg;
  assign doneOut  = doneReg;

  // R3: the binary GCD must never be stepped once an operand has reached zero
  p_gcd_live_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.gcdStep |-> ((gu != '0) && (gv != '0)));

endmodule

// File: rtl/rational_tuning_calc.sv
module rational_tuning_calc
  import tw_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2*WORD_W-1:0] ratioM,
  input  logic [2*WORD_W-1:0] ratioN,
  output logic [WORD_W-1:0]   wordX,
  output logic [WORD_W-1:0]   fracA,
  output logic [WORD_W-1:0]   fracB,
  output logic                resultValid,
  output logic                modNeeded,
  output logic                done
);
  twStrobe_t st;
  logic inputOk, remZero, gcdDone, busy;

  tw_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .inputOk (inputOk),
    .remZero (remZero),
    .gcdDone (gcdDone),
    .st      (st),
    .busy    (busy)
  );

  tw_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .mIn      (ratioM),
    .nIn      (ratioN),
    .inputOk  (inputOk),
    .remZero  (remZero),
    .gcdDone  (gcdDone),
    .xOut     (wordX),
    .aOut     (fracA),
    .bOut     (fracB),
    .validOut (resultValid),
    .modOut   (modNeeded),
    .doneOut  (done)
  );

  p_reject_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !resultValid) |-> ((wordX == '0) && (fracA == '0) && (fracB == '0) && !modNeeded));

  p_exact_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && resultValid && !modNeeded) |-> ((fracA == '0) && (fracB == WORD_W'(1))));

  p_proper_frac_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && modNeeded) |-> (resultValid && (fracA != '0) && (fracA < fracB)));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable({wordX, fracA, fracB, resultValid, modNeeded}));

endmodule

// File: tb/rational_tuning_calc_bench.sv
`timescale 1ns/1ps
module rational_tuning_calc_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ratioM = '0, ratioN = '0;
  logic [31:0] wordX, fracA, fracB;
  logic        resultValid, modNeeded, done;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  rational_tuning_calc u_rational_tuning_calc (
    .clk(clk), .rstN(rstN), .start(start), .ratioM(ratioM), .ratioN(ratioN),
    .wordX(wordX), .fracA(fracA), .fracB(fracB),
    .resultValid(resultValid), .modNeeded(modNeeded), .done(done)
  );

  // kind: 0 fractional, 1 exact (Y=0), 2 bad N, 3 ratio too high
  localparam int NV = 13;
  localparam logic [63:0] T_M [NV] = '{
    64'd1, 64'd50000000, 64'd1, 64'd3, 64'd1, 64'd1, 64'd0,
    64'd1, 64'd1, 64'd5, 64'd4, 64'd1, 64'd1};
  localparam logic [63:0] T_N [NV] = '{
    64'd10, 64'd499999999, 64'd8, 64'd7, 64'h2_0000_0000, 64'h1_0000_0000, 64'd5,
    64'd2, 64'h1_0000_0001, 64'd10, 64'd9, 64'hFFFF_FFFF_0000_0000, 64'd3};
  localparam logic [31:0] T_X [NV] = '{
    32'd429496729, 32'd429496730, 32'd536870912, 32'd1840700269, 32'd0, 32'd1, 32'd0,
    32'd0, 32'd0, 32'd0, 32'd1908874353, 32'd0, 32'd1431655765};
  localparam logic [31:0] T_A [NV] = '{
    32'd3, 32'd229496730, 32'd0, 32'd5, 32'd1, 32'd0, 32'd0,
    32'd0, 32'd0, 32'd0, 32'd7, 32'd1, 32'd1};
  localparam logic [31:0] T_B [NV] = '{
    32'd5, 32'd499999999, 32'd1, 32'd7, 32'd2, 32'd1, 32'd1,
    32'd0, 32'd0, 32'd0, 32'd9, 32'hFFFF_FFFF, 32'd3};
  localparam int T_K [NV] = '{0, 0, 1, 0, 0, 1, 1, 2, 2, 3, 0, 0, 0};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] euclid(input logic [63:0] a0, input logic [63:0] b0);
    logic [63:0] a = a0, b = b0, t;
    while (b != 0) begin
      t = a % b; a = b; b = t;
    end
    return a;
  endfunction

  task automatic model(input logic [63:0] m, input logic [63:0] n,
                       output logic ok, output logic md,
                       output logic [31:0] x, output logic [31:0] a, output logic [31:0] b);
    logic [127:0] prod, q, y;
    logic [63:0] g;
    logic nOk;
    nOk = (n >= 64'd3 && n <= 64'h1_0000_0000) ||
          (n[31:0] == 32'd0 && n[63:32] >= 32'd2);
    ok = nOk && ({m, 1'b0} < {1'b0, n});
    md = 1'b0; x = '0; a = '0; b = '0;
    if (ok) begin
      prod = {64'd0, m} << 32;
      q = prod / {64'd0, n};
      y = prod - q * {64'd0, n};
      x = q[31:0];
      if (y == 0) begin
        b = 32'd1;
      end else begin
        md = 1'b1;
        g = euclid(y[63:0], n);
        a = 32'(y[63:0] / g);
        b = 32'(n / g);
      end
    end
  endtask

  // Drives one request and waits for done; checks R8 and R10 along the way.
  task automatic run(input logic [63:0] m, input logic [63:0] n);
    int lat;
    @(negedge clk);
    ratioM = m; ratioN = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 latency bound", 64'(lat <= 512), 64'd1);
    @(negedge clk);
    chk("R8 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic check_result(input string base, input logic ok, input logic md,
                              input logic [31:0] x, input logic [31:0] a, input logic [31:0] b);
    chk({base, " valid"}, 64'(resultValid), 64'(ok));
    chk({base, " mod flag"}, 64'(modNeeded), 64'(md));
    chk({base, " X"}, 64'(wordX), 64'(x));
    chk({base, " A"}, 64'(fracA), 64'(a));
    chk({base, " B"}, 64'(fracB), 64'(b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;
    logic ok, md;
    logic [31:0] x, a, b;
    int dones;

    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 valid", 64'(resultValid), 64'd0);
    chk("R1 mod", 64'(modNeeded), 64'd0);
    chk("R1 X/A/B", {wordX, fracA | fracB}, 64'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      run(T_M[i], T_N[i]);
      case (T_K[i])
        0: tag = "R2 R3 R7 table";
        1: tag = "R2 R6 table";
        2: tag = "R4 table";
        default: tag = "R5 table";
      endcase
      check_result(tag, T_K[i] < 2, T_K[i] == 0, T_X[i], T_A[i], T_B[i]);
    end

    // R2 R3: pseudo-random valid pairs against an independent 128-bit model
    for (int i = 0; i < 24; i++) begin
      logic [63:0] n, m;
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      if (i % 3 == 2)
        n = ({32'd0, seed[63:32]} % 64'd4294967294 + 64'd2) << 32;
      else
        n = {32'd0, seed[63:32]} % 64'd4294967294 + 64'd3;
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      m = seed % ((n + 64'd1) / 64'd2);
      model(m, n, ok, md, x, a, b);
      run(m, n);
      check_result("R2 R3 random", ok, md, x, a, b);
    end

    // R4: boundary N values
    model(64'd1, 64'hFFFF_FFFF_FFFF_FFFF, ok, md, x, a, b);
    run(64'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    check_result("R4 N all ones", ok, md, x, a, b);
    run(64'd0, 64'd0);
    check_result("R4 N zero", 1'b0, 1'b0, 32'd0, 32'd0, 32'd0);

    // R9: second start while busy is ignored
    @(negedge clk);
    ratioM = 64'd1; ratioN = 64'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    ratioM = 64'd3; ratioN = 64'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    for (int c = 0; c < 600; c++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk("R9 single done", 64'(dones), 64'd1);
    check_result("R9 first operands kept", 1'b1, 1'b1, 32'd429496729, 32'd3, 32'd5);
    // R8: outputs still held long after completion
    repeat (50) @(negedge clk);
    check_result("R8 hold", 1'b1, 1'b1, 32'd429496729, 32'd3, 32'd5);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule